// File: doc/BRIEF.md
# Pipelined Instruction Fetch Master

This block is the bus side of a processor front end. After the core names a target address, the block streams read requests for consecutive 32-bit instruction words onto a pipelined memory-mapped bus. That bus stalls requests with a wait-request line and returns data later, in request order, on a separate read-data-valid strobe. Several reads can be in flight at once. Each returned word goes into a small return buffer together with the address it was fetched from. The core drains the buffer through a ready/valid handshake.

When the core redirects the stream, for example on a predicted branch, the block clears its return buffer. It records how many reads of the old stream are still outstanding and drops exactly that many returning beats. It then delivers only words of the new stream. Issue is limited by credit, so a return can never find the buffer full. The block never writes.

Top module: `ifetch_master`

## Requirements
- R1: The write strobe `bus_write` is never asserted; the block only reads.
- R2: The first request after a redirect targets `redirect_addr` with its two low bits forced to zero. Each further request of the same stream is 4 above the previous one. Every request address has bits [1:0] equal to 0.
- R3: While `bus_read` is high and `bus_waitreq` is high, `bus_read` stays high and `bus_addr` keeps its value on the next cycle. A request counts as accepted only in a cycle where `bus_waitreq` is low.
- R4: Up to DEPTH (default 4) accepted requests may be awaiting data at the same time, and never more.
- R5: A new request is issued only while awaiting requests, buffered words and the pending request together number fewer than DEPTH. A stalled consumer therefore causes no word to be lost: once the buffer holds DEPTH words, issue stops.
- R6: A redirect empties the return buffer, so `out_valid` is low in the cycle after the redirect is sampled.
- R7: Read-data-valid beats that belong to requests accepted before a redirect (including a request stalled under wait-request when the redirect arrived) are discarded. The first word delivered after a redirect is the word at the new target.
- R8: Words are delivered in request order. `out_pc` carries the fetch address of `out_word`, and a word leaves the buffer on a cycle with `out_valid` and `out_ready` both high.
- R9: After reset, `bus_read` and `out_valid` are low, and no request is issued until the first redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect | input | 1 | Start or restart the fetch stream at `redirect_addr` |
| redirect_addr | input | 32 | New fetch target (low two bits ignored) |
| bus_read | output | 1 | Read request |
| bus_write | output | 1 | Write request, held low |
| bus_addr | output | 32 | Request byte address |
| bus_waitreq | input | 1 | Slave stalls the current request |
| bus_rdata | input | 32 | Returned read data |
| bus_rvalid | input | 1 | `bus_rdata` holds data for the oldest open request |
| out_valid | output | 1 | A fetched word is available to the core |
| out_ready | input | 1 | Core accepts the word |
| out_pc | output | 32 | Fetch address of `out_word` |
| out_word | output | 32 | Fetched instruction word |

## Verification
The hardest case to reach is a redirect that lands while a request is frozen under wait-request and older reads are still returning. In that case the stalled request must still be counted among the beats to drop, even though it has not been accepted yet. The bench has a slave model with its own random latency and stall ratio. It forces this case directly by holding wait-request high across a redirect. It also runs a long random phase with frequent redirects and a stalling consumer. Each word the model returns is a hash of its address, so a stale beat that reaches the output shows up as a word/address mismatch.

// File: rtl/ifm_pkg.sv
package ifm_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] word;
  } fetch_beat_t;
endpackage

// File: rtl/ifm_ret_buf.sv
module ifm_ret_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             valid,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_pop;

  assign valid  = (count != '0);
  assign do_pop = pop && valid;
  assign dout   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // storage without reset so it can map onto memory primitives
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (count < CNT_W'(DEPTH))); // R5
endmodule

// File: rtl/ifm_tracker.sv
module ifm_tracker #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redirect,
  input  logic             accept,
  input  logic             accept_stale,
  input  logic             rvalid,
  output logic             keep,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] discard
);
  logic             drop;
  logic [SUM_W-1:0] live_n, disc_n;

  assign drop = rvalid && (redirect || discard != '0);
  assign keep = rvalid && !drop;

  always_comb begin
    if (redirect) begin
      live_n = '0;
      disc_n = SUM_W'(live) + SUM_W'(discard) + SUM_W'(accept) - SUM_W'(rvalid);
    end else begin
      live_n = SUM_W'(live) + SUM_W'(accept && !accept_stale) - SUM_W'(keep);
      disc_n = SUM_W'(discard) + SUM_W'(accept && accept_stale)
             - SUM_W'(rvalid && discard != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      discard <= '0;
    end else begin
      live    <= live_n[CNT_W-1:0];
      discard <= disc_n[CNT_W-1:0];
    end
  end

  AST_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (SUM_W'(live) + SUM_W'(discard)) <= SUM_W'(DEPTH)); // R4
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (live != '0 || discard != '0)); // R7
  AST_FRESH_AFTER_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (live == '0)); // R7
endmodule

// File: rtl/ifm_req_gen.sv
module ifm_req_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              waitreq,
  input  logic              room,
  output logic              bus_read,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              accept,
  output logic              stale
);
  logic [ADDR_W-1:0] next_addr;
  logic              running;
  logic              free;

  assign accept = bus_read && !waitreq;
  assign free   = !bus_read || accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_read  <= 1'b0;
      bus_addr  <= '0;
      next_addr <= '0;
      running   <= 1'b0;
      stale     <= 1'b0;
    end else if (redirect) begin
      running   <= 1'b1;
      next_addr <= redirect_addr & ~ADDR_W'(3);
      if (free) begin
        bus_read <= 1'b0;
        stale    <= 1'b0;
      end else begin
        stale    <= 1'b1;
      end
    end else if (free) begin
      stale <= 1'b0;
      if (running && room) begin
        bus_read  <= 1'b1;
        bus_addr  <= next_addr;
        next_addr <= next_addr + ADDR_W'(4);
      end else begin
        bus_read  <= 1'b0;
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (bus_read && waitreq) |=> (bus_read && $stable(bus_addr))); // R3
  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    bus_read |-> (bus_addr[1:0] == 2'b00)); // R2
  AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (rst)
    !running |-> !bus_read); // R9
endmodule

// File: rtl/ifetch_master.sv
module ifetch_master #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        redirect,
  input  logic [31:0] redirect_addr,
  output logic        bus_read,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  input  logic        bus_waitreq,
  input  logic [31:0] bus_rdata,
  input  logic        bus_rvalid,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_pc,
  output logic [31:0] out_word
);
  import ifm_pkg::*;

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int USED_W = CNT_W + 2;
  localparam int BEAT_W = $bits(fetch_beat_t);

  logic             accept, stale, keep, room;
  logic [CNT_W-1:0] live, discard, buf_count;
  logic [USED_W-1:0] used;
  logic [ADDR_W-1:0] resp_pc;
  fetch_beat_t      in_beat, head_beat;

  assign bus_write = 1'b0;

  assign used = USED_W'(live) + USED_W'(discard) + USED_W'(buf_count) + USED_W'(bus_read);
  assign room = used < USED_W'(DEPTH);

  ifm_req_gen #(.ADDR_W(ADDR_W)) u_req (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_addr(redirect_addr),
    .waitreq(bus_waitreq), .room(room), .bus_read(bus_read),
    .bus_addr(bus_addr), .accept(accept), .stale(stale)
  );

  ifm_tracker #(.DEPTH(DEPTH)) u_trk (
    .clk(clk), .rst(rst), .redirect(redirect), .accept(accept),
    .accept_stale(stale), .rvalid(bus_rvalid), .keep(keep),
    .live(live), .discard(discard)
  );

  // address label for the next kept beat; returns come back in request order
  always_ff @(posedge clk) begin
    if (rst)           resp_pc <= '0;
    else if (redirect) resp_pc <= redirect_addr & ~ADDR_W'(3);
    else if (keep)     resp_pc <= resp_pc + ADDR_W'(4);
  end

  assign in_beat.pc   = resp_pc;
  assign in_beat.word = bus_rdata;

  ifm_ret_buf #(.DEPTH(DEPTH), .W(BEAT_W)) u_buf (
    .clk(clk), .rst(rst), .flush(redirect), .push(keep), .din(in_beat),
    .pop(out_ready), .dout(head_beat), .valid(out_valid), .count(buf_count)
  );

  assign out_pc   = head_beat.pc;
  assign out_word = head_beat.word;

  AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !out_valid); // R6
  AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_read |-> !bus_write); // R1
endmodule

// File: tb/ifetch_master_test.sv
`timescale 1ns/1ps
module ifetch_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redirect = 1'b0;
  logic [31:0] redirect_addr = '0;
  logic        bus_read, bus_write;
  logic [31:0] bus_addr;
  logic        bus_waitreq = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_rvalid = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pc, out_word;

  always #2.5 clk = ~clk;

  ifetch_master uut (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_addr(redirect_addr),
    .bus_read(bus_read), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_word(out_word)
  );

  int checks = 0;
  int fails  = 0;

  // slave model: in-order response queue
  logic [31:0] q_addr [16];
  int          q_time [16];
  int q_head = 0, q_tail = 0, q_n = 0, last_time = 0, cyc = 0;
  int lat_min = 1, lat_max = 3, max_q = 0, delivered = 0;
  logic [31:0] exp_pc = '0;
  bit prev_stall = 0, want_empty = 0, first_after = 0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int wr_pct, input int rdy_pct, input bit redir,
                      input logic [31:0] tgt);
    bit wr, rdy, acc;
    int t;
    @(negedge clk);
    cyc++;
    check(bus_write == 1'b0, "R1", {31'd0, bus_write}, 32'd0);
    if (bus_read) check(bus_addr[1:0] == 2'b00, "R2", bus_addr, bus_addr & ~32'd3);
    if (prev_stall) begin
      check(bus_read == 1'b1, "R3", {31'd0, bus_read}, 32'd1);
      check(bus_addr == prev_addr, "R3", bus_addr, prev_addr);
    end
    check(q_n <= 4, "R4", q_n, 32'd4);
    if (want_empty) check(out_valid == 1'b0, "R6", {31'd0, out_valid}, 32'd0);
    wr  = ($urandom % 100) < wr_pct;
    rdy = ($urandom % 100) < rdy_pct;
    // response beat for this cycle
    if (q_n > 0 && q_time[q_head] <= cyc) begin
      bus_rvalid = 1'b1;
      bus_rdata  = mem_word(q_addr[q_head]);
      q_head = (q_head + 1) % 16;
      q_n--;
    end else begin
      bus_rvalid = 1'b0;
      bus_rdata  = $urandom;
    end
    acc = bus_read && !wr;
    if (acc) begin
      t = cyc + lat_min + ($urandom % (lat_max - lat_min + 1));
      if (t <= last_time) t = last_time + 1;
      last_time = t;
      q_addr[q_tail] = bus_addr;
      q_time[q_tail] = t;
      q_tail = (q_tail + 1) % 16;
      q_n++;
      if (q_n > max_q) max_q = q_n;
    end
    if (out_valid && rdy) begin
      check(out_pc == exp_pc, first_after ? "R7" : "R8", out_pc, exp_pc);
      check(out_word == mem_word(exp_pc), "R8", out_word, mem_word(exp_pc));
      exp_pc = exp_pc + 32'd4;
      first_after = 0;
      delivered++;
    end
    if (redir) begin
      exp_pc = tgt & ~32'd3;
      first_after = 1;
    end
    want_empty = redir;
    prev_stall = bus_read && wr;
    prev_addr  = bus_addr;
    bus_waitreq   = wr;
    out_ready     = rdy;
    redirect      = redir;
    redirect_addr = tgt;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(bus_read == 1'b0, "R9", {31'd0, bus_read}, 32'd0);
    check(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    // no stream yet: nothing may be requested
    repeat (6) tick(0, 100, 0, 0);
    check(bus_read == 1'b0, "R9", {31'd0, bus_read}, 32'd0);
    // misaligned target: stream starts at the aligned word
    tick(0, 100, 1, 32'h0000_1003);
    repeat (40) tick(0, 100, 0, 0);
    check(delivered > 20, "R2", delivered, 32'd20);
    // long latency, no stalls: several reads must be in flight
    lat_min = 4; lat_max = 6; max_q = 0;
    tick(0, 100, 1, 32'h0000_2000);
    repeat (60) tick(0, 100, 0, 0);
    check(max_q == 4, "R4", max_q, 32'd4);
    // consumer stalls: buffer fills to capacity and issue stops
    lat_min = 1; lat_max = 3;
    repeat (30) tick(0, 0, 0, 0);
    check(q_n == 0, "R5", q_n, 32'd0);
    check(bus_read == 1'b0, "R5", {31'd0, bus_read}, 32'd0);
    check(out_valid == 1'b1, "R5", {31'd0, out_valid}, 32'd1);
    delivered = 0;
    repeat (4) tick(0, 100, 0, 0);
    check(delivered == 4, "R5", delivered, 32'd4);
    // redirect while a request is frozen under wait-request
    repeat (3) tick(0, 100, 0, 0);
    repeat (4) tick(100, 100, 0, 0);
    tick(100, 100, 1, 32'h0000_8000);
    repeat (5) tick(100, 100, 0, 0);
    delivered = 0;
    repeat (40) tick(0, 100, 0, 0);
    check(delivered > 10, "R7", delivered, 32'd10);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit r;
      r = ($urandom % 100) < 4;
      lat_max = 1 + ($urandom % 5);
      lat_min = 1;
      tick(30, 70, r, $urandom & 32'h000F_FFFF);
    end
    repeat (40) tick(0, 100, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule